// File: doc/BRIEF.md
# Key-Protected Reset Control Register

This block is a 32-bit control register on a simple single-cycle register bus. The bus has an address, a write enable, write data and combinational read data. A write to the control word takes effect only when its upper half carries the unlock key. The key check and every field of the update happen in one bus transaction, so a key written earlier never opens the door for a later write.

The control word holds three things. The first is a 3-bit priority-grouping field that a neighbouring interrupt controller decodes. The second is an endianness indicator fixed at build time. The third is a self-clearing request bit that starts a system reset.

A small sequencer turns an accepted request into a reset pulse of fixed length on the system reset output. The debug-domain reset output is never asserted by this path. When the sequencer starts, it records software reset as the cause in a sticky status word. That flag survives the pulse it caused. Software clears it by writing 1 to it, and the power-on reset also clears it.

Top module: `rstctl_top`

## Requirements
- R1: A write to the control address whose bits [31:16] differ from 0x05FA is discarded entirely. The grouping field keeps its value, and no reset starts even when bit 2 is 1.
- R2: Reading the control address always returns 0xFA05 in bits [31:16], and bit 2 always reads 0.
- R3: Bit 15 of the control read value equals the BIG_ENDIAN parameter (default 0, little-endian), and writes never change it.
- R4: Bits [10:8] hold the grouping field. A write carrying the correct key loads it, and it reads back the value written. Power-on reset leaves it at 0.
- R5: A keyed write with bit 2 set raises the system reset output from the first cycle after the write's clock edge. The output stays high for PULSE_CYCLES consecutive cycles (default 16) and then falls synchronously.
- R6: A keyed write with bit 2 clear arms nothing. A following write with bit 2 set but a wrong key causes no reset.
- R7: Bits [14:11], [7:3], 1 and 0 of the control word read as 0. Writing 1s to them has no observable effect.
- R8: The debug-domain reset output stays 0 at all times, including during a software-requested reset.
- R9: When the reset pulse starts, bit 0 of the status address becomes 1. It stays 1 through and after the pulse.
- R10: Writing 1 to bit 0 of the status address clears the flag. Writing 0 leaves it set.
- R11: A request that arrives while the pulse is active is ignored, and the pulse is not lengthened.
- R12: The software reset pulse clears the grouping field to 0. Power-on reset clears the grouping field, the sequencer and the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | ADDR_W | Register address (control at CTRL_ADDR, status at STAT_ADDR) |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| sys_rst_o | output | 1 | System reset pulse to all non-debug domains |
| dbg_rst_o | output | 1 | Debug-domain reset, held deasserted |

## Verification
Read data is combinational, so each read is compared in the same cycle its address is driven. A write commits at the next clock edge, and its effect on a read becomes visible in the following cycle. The reset output rises one cycle after the edge that captures an accepted request and stays high for exactly PULSE_CYCLES cycles.

The bench stamps each expected item with the cycle number in which it falls due. A monitor compares items only at the falling edge of that cycle. Pin checks for a pulse cover the cycle before it rises, each cycle it is high and the first cycle after it falls, so a pulse that starts early or late, or is too long or too short, is caught.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned GRP_W      = 3;
    localparam int unsigned KEY_LSB    = 16;
    localparam int unsigned ENDIAN_BIT = 15;
    localparam int unsigned GRP_LSB    = 8;
    localparam int unsigned REQ_BIT    = 2;

    localparam logic [15:0] UNLOCK_KEY   = 16'h05FA;
    localparam logic [15:0] READBACK_TAG = 16'hFA05;

    typedef struct packed {
        logic             key_ok;
        logic [GRP_W-1:0] grp;
        logic             rst_req;
    } ctrl_wr_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_PULSE = 1'b1
    } seq_state_e;

    function automatic ctrl_wr_t decode_ctrl_write(input logic [DATA_W-1:0] w);
        ctrl_wr_t d;
        d.key_ok  = (w[KEY_LSB +: 16] == UNLOCK_KEY);
        d.grp     = w[GRP_LSB +: GRP_W];
        d.rst_req = w[REQ_BIT];
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl_read(input logic endian,
                                                        input logic [GRP_W-1:0] grp);
        logic [DATA_W-1:0] r;
        r                      = '0;
        r[KEY_LSB +: 16]       = READBACK_TAG;
        r[ENDIAN_BIT]          = endian;
        r[GRP_LSB +: GRP_W]    = grp;
        return r;
    endfunction

endpackage

// File: rtl/rstctl_keyreg.sv
module rstctl_keyreg
    import rstctl_pkg::*;
(
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [GRP_W-1:0]  grp_q,
    output logic              rst_req
);

    ctrl_wr_t dec;

    always_comb begin
        dec     = decode_ctrl_write(wdata);
        rst_req = wr_en & dec.key_ok & dec.rst_req;
    end

    // Power-on has priority, then the software reset pulse, then a keyed write.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            grp_q <= '0;
        end else if (sys_rst) begin
            grp_q <= '0;
        end else if (wr_en && dec.key_ok) begin
            grp_q <= dec.grp;
        end
    end

endmodule

// File: rtl/rstctl_seq.sv
module rstctl_seq
    import rstctl_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic por_rst,
    input  logic req,
    output logic start,
    output logic sys_rst
);

    localparam int unsigned CNT_W = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] remain;

    assign start   = req && (state == SEQ_IDLE);
    assign sys_rst = (state == SEQ_PULSE);

    always_ff @(posedge clk) begin
        if (por_rst) begin
            state  <= SEQ_IDLE;
            remain <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (req) begin
                        state  <= SEQ_PULSE;
                        remain <= LOAD_VAL;
                    end
                end
                SEQ_PULSE: begin
                    if (remain == '0) begin
                        state <= SEQ_IDLE;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rstctl_status.sv
module rstctl_status (
    input  logic clk,
    input  logic por_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    // A new cause wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned CTRL_ADDR    = 0,
    parameter int unsigned STAT_ADDR    = 1,
    parameter int unsigned PULSE_CYCLES = 16,
    parameter bit          BIG_ENDIAN   = 1'b0
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sys_rst_o,
    output logic              dbg_rst_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic             sel_ctrl;
    logic             sel_stat;
    logic [GRP_W-1:0] grp_q;
    logic             rst_req;
    logic             seq_start;
    logic             sw_flag;

    assign sel_ctrl = (bus_addr == CTRL_A);
    assign sel_stat = (bus_addr == STAT_A);

    rstctl_keyreg u_keyreg (
        .clk     (clk),
        .por_rst (por_rst),
        .sys_rst (sys_rst_o),
        .wr_en   (bus_we && sel_ctrl),
        .wdata   (bus_wdata),
        .grp_q   (grp_q),
        .rst_req (rst_req)
    );

    rstctl_seq #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_seq (
        .clk     (clk),
        .por_rst (por_rst),
        .req     (rst_req),
        .start   (seq_start),
        .sys_rst (sys_rst_o)
    );

    rstctl_status u_status (
        .clk     (clk),
        .por_rst (por_rst),
        .set_i   (seq_start),
        .clr_i   (bus_we && sel_stat && bus_wdata[0]),
        .flag_q  (sw_flag)
    );

    // The debug domain is never reset by this block.
    assign dbg_rst_o = 1'b0;

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = pack_ctrl_read(BIG_ENDIAN, grp_q);
        end else if (sel_stat) begin
            bus_rdata[0] = sw_flag;
        end
    end

endmodule

// File: rtl/rstctl_checker.sv
module rstctl_checker
    import rstctl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 4,
    parameter int unsigned CTRL_ADDR    = 0,
    parameter int unsigned PULSE_CYCLES = 16
) (
    input logic              clk,
    input logic              por_rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              sys_rst_o,
    input logic              dbg_rst_o,
    input logic [GRP_W-1:0]  grp_q,
    input logic              sw_flag
);

    localparam int unsigned RW = $clog2(PULSE_CYCLES + 2);

    logic          to_ctrl;
    logic          keyed_req;
    logic          bad_key_wr;
    logic [RW-1:0] run_len;

    assign to_ctrl    = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign keyed_req  = to_ctrl && (bus_wdata[31:16] == 16'h05FA) && bus_wdata[2];
    assign bad_key_wr = to_ctrl && (bus_wdata[31:16] != 16'h05FA);

    always_ff @(posedge clk) begin
        if (por_rst) begin
            run_len <= '0;
        end else if (sys_rst_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_badkey_no_reset_R1: assert property (@(posedge clk) disable iff (por_rst)
        (bad_key_wr && !sys_rst_o) |=> !sys_rst_o);

    assert_readback_tag_R2: assert property (@(posedge clk) disable iff (por_rst)
        (bus_addr == ADDR_W'(CTRL_ADDR)) |-> (bus_rdata[31:16] == 16'hFA05 && !bus_rdata[2]));

    assert_request_starts_R5: assert property (@(posedge clk) disable iff (por_rst)
        (keyed_req && !sys_rst_o) |=> sys_rst_o);

    assert_debug_quiet_R8: assert property (@(posedge clk) disable iff (por_rst)
        !dbg_rst_o);

    assert_cause_flag_R9: assert property (@(posedge clk) disable iff (por_rst)
        $rose(sys_rst_o) |-> sw_flag);

    assert_pulse_bounded_R11: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst_o |-> (run_len < RW'(PULSE_CYCLES)));

    assert_pulse_length_R5: assert property (@(posedge clk) disable iff (por_rst)
        $fell(sys_rst_o) |-> (run_len == RW'(PULSE_CYCLES)));

    assert_grp_cleared_R12: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst_o |=> (grp_q == '0));

endmodule

bind rstctl_top rstctl_checker #(
    .ADDR_W       (ADDR_W),
    .CTRL_ADDR    (CTRL_ADDR),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk       (clk),
    .por_rst   (por_rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sys_rst_o (sys_rst_o),
    .dbg_rst_o (dbg_rst_o),
    .grp_q     (grp_q),
    .sw_flag   (sw_flag)
);

// File: tb/rstctl_top_test.sv
`timescale 1ns/1ps
module rstctl_top_test;

    localparam int PULSE = 16;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_STAT = 4'd1;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_o;
    logic        dbg_rst_o;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        bit          pins;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rstctl_top #(.PULSE_CYCLES(PULSE)) uut (
        .clk       (clk),
        .por_rst   (por_rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sys_rst_o (sys_rst_o),
        .dbg_rst_o (dbg_rst_o)
    );

    // Monitor: compare every item that falls due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.pins ? {30'b0, dbg_rst_o, sys_rst_o} : bus_rdata;
            n_cmp++;
            if (it.due != cyc || act !== it.exp) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual %h expected %h", it.tag, cyc, act, it.exp);
            end
        end
    end

    task automatic push(input int due, input bit pins, input logic [31:0] exp, input string tag);
        item_t it;
        it.due = due; it.pins = pins; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        push(cyc, 1'b0, exp, tag);
        @(posedge clk); #1;
    endtask

    task automatic pins_now(input logic [1:0] exp, input string tag);
        push(cyc, 1'b1, {30'b0, exp}, tag);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Expect a pulse starting one cycle after the next write edge.
    task automatic expect_pulse(input string tag);
        int c;
        c = cyc;
        for (int k = 0; k <= PULSE + 1; k++) begin
            push(c + k, 1'b1, {31'b0, (k >= 1 && k <= PULSE)}, tag);
        end
    endtask

    initial begin
        idle(3);
        por_rst = 1'b0;
        idle(1);

        // Reset state
        rd(A_CTRL, 32'hFA05_0000, "R4 reset ctrl");
        rd(A_STAT, 32'h0, "R9 reset status");
        pins_now(2'b00, "R8 reset pins");

        // Keyed grouping write
        wr(A_CTRL, 32'h05FA_0500);
        rd(A_CTRL, 32'hFA05_0500, "R4 grp=5");
        wr(A_CTRL, 32'h05FA_0700);
        rd(A_CTRL, 32'hFA05_0700, "R4 grp=7");

        // Wrong keys
        wr(A_CTRL, 32'h1234_0300);
        rd(A_CTRL, 32'hFA05_0700, "R1 bad key grp kept");
        wr(A_CTRL, 32'hFA05_0104);
        rd(A_CTRL, 32'hFA05_0700, "R1 readback tag as key rejected");
        pins_now(2'b00, "R1 no reset after bad key");
        pins_now(2'b00, "R1 no reset after bad key +1");

        // Reserved, debug bits and endian bit
        wr(A_CTRL, 32'h05FA_FAFB);
        rd(A_CTRL, 32'hFA05_0200, "R7 R3 reserved/endian ignored");

        // Key not remembered
        wr(A_CTRL, 32'h05FA_0100);
        wr(A_CTRL, 32'h0000_0004);
        pins_now(2'b00, "R6 unkeyed request no reset");
        pins_now(2'b00, "R6 unkeyed request no reset +1");
        rd(A_CTRL, 32'hFA05_0100, "R6 grp from keyed write only");

        // Software reset
        expect_pulse("R5 R8 pulse");
        wr(A_CTRL, 32'h05FA_0304);
        idle(PULSE + 1);
        rd(A_CTRL, 32'hFA05_0000, "R12 R2 grp cleared, bit2 reads 0");
        rd(A_STAT, 32'h1, "R9 flag survives reset");

        // Status clearing
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, 32'h1, "R10 write 0 keeps flag");
        wr(A_STAT, 32'h0000_0001);
        rd(A_STAT, 32'h0, "R10 write 1 clears flag");

        // Request during pulse is ignored
        expect_pulse("R11 no extension");
        wr(A_CTRL, 32'h05FA_0004);
        idle(4);
        wr(A_CTRL, 32'h05FA_0004);
        wr(A_STAT, 32'h0000_0001);
        idle(PULSE - 6);
        rd(A_STAT, 32'h0, "R11 mid-pulse request did not set flag");
        rd(A_STAT, 32'h0, "R11 status after pulse");

        // Power-on clears everything
        expect_pulse("R5 second pulse");
        wr(A_CTRL, 32'h05FA_0004);
        idle(PULSE + 1);
        wr(A_CTRL, 32'h05FA_0600);
        rd(A_CTRL, 32'hFA05_0600, "R4 grp=6 before por");
        rd(A_STAT, 32'h1, "R9 flag before por");
        por_rst = 1'b1;
        idle(2);
        por_rst = 1'b0;
        rd(A_CTRL, 32'hFA05_0000, "R12 por clears grp");
        rd(A_STAT, 32'h0, "R12 por clears flag");
        pins_now(2'b00, "R12 R8 pins after por");

        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule